// File: doc/BRIEF.md
# Power-Button Key Auto-Block

This block sits between a small set of key input lines and their outputs. In normal operation each key output follows its input through one register. When the feature is armed and the power button is pressed, the block first confirms that the press is real. It does this by sampling the button on a slow 200 kHz strobe and requiring the button to stay low for a programmable number of strobe periods. Once the press is confirmed, the key outputs that software selected are held at fixed programmed levels. The hold lasts until the button is let go.

The control word packs the qualification length, in 5 µs strobe steps, into its low bits, with the arming bit just above them. A separate select bit and a separate forced level exist for each key. A typical use is to hide key activity from the rest of the system, or to hold a line at a chosen level, while the power button is down.

Top module: `pwrkey_autoblock`

## Requirements
- R1: When the arming bit `ab_ctrl_i[DBW]` (bit 16 by default) is 0, no key output is ever forced. Every output keeps following its input.
- R2: A press starts only on a falling edge as seen on strobe cycles. The button level sampled at the previous strobe must be 1 and the level at the current strobe must be 0. Button activity between strobes plays no part in edge detection.
- R3: Let N be `ab_ctrl_i[DBW-1:0]`. The override becomes active at the N-th strobe after the edge strobe, provided the button is low at each of those strobes. With N = 0 it becomes active at the edge strobe itself. Outputs show the override one clock after the block turns active.
- R4: A strobe that sees the button high during qualification, or sees the arming bit low, drops the press. A fresh high-to-low edge is then needed.
- R5: While the override is active, each key i with `key_sel_i[i]` = 1 drives `keys_o[i]` = `key_val_i[i]`.
- R6: A key that is not selected, or any key while the override is inactive, gives `keys_o[i]` equal to `keys_i[i]` from the previous clock.
- R7: While active, a clock edge that sees the button high ends the override at once, with no strobe needed. Outputs return to pass-through one clock later.
- R8: If the arming bit is 0 at a strobe while the override is active, the override ends at that strobe.
- R9: Synchronous reset clears `keys_o` to 0 and leaves the block idle. The stored previous button sample is cleared to low, so a button held low through reset must be seen high before a press can start.
- R10: The qualification count never wraps. The largest value of N, 2^DBW-1, is honoured in full, and a lower N written during qualification takes effect at the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-clock strobe at the 200 kHz step rate |
| btn_i | input | 1 | Power-button level, low when pressed |
| keys_i | input | NKEY | Key input levels |
| ab_ctrl_i | input | DBW+1 | Bit DBW arms the feature; bits DBW-1:0 hold the qualification count |
| key_sel_i | input | NKEY | Per-key override select |
| key_val_i | input | NKEY | Per-key forced level |
| keys_o | output | NKEY | Registered key outputs |

## Verification
The bench builds the block with three keys and a 6-bit count field, so DBW = 6. The narrower count lets the largest qualification value, 63 strobes, be held and reached within a short run, which exercises the no-wrap corner. The strobe spacing is varied between every clock and every fifth clock. This puts button edges, releases and changes to the arming bit both on and between strobes.

// File: rtl/pab_pkg.sv
package pab_pkg;

  typedef enum logic [1:0] {
    AB_IDLE = 2'd0,
    AB_QUAL = 2'd1,
    AB_HOLD = 2'd2
  } ab_state_e;

endpackage

// File: rtl/pab_edge_sampler.sv
module pab_edge_sampler (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic lvl_i,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
    end else if (tick_i) begin
      prev_q <= lvl_i;
    end
  end

  assign fall_o = tick_i & prev_q & ~lvl_i;

endmodule

// File: rtl/pab_press_fsm.sv
module pab_press_fsm
  import pab_pkg::*;
#(
  parameter int DBW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick_i,
  input  logic           en_i,
  input  logic           lvl_i,
  input  logic           fall_i,
  input  logic [DBW-1:0] limit_i,
  output logic           active_o
);

  localparam int CW = DBW + 1;

  ab_state_e     state_q, state_d;
  logic [DBW-1:0] cnt_q, cnt_d;
  logic [CW-1:0]  cnt_inc;
  logic           reached;

  assign cnt_inc = {1'b0, cnt_q} + CW'(1);
  assign reached = (cnt_inc >= {1'b0, limit_i});

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      AB_IDLE: begin
        if (fall_i && en_i) begin
          cnt_d   = '0;
          state_d = (limit_i == '0) ? AB_HOLD : AB_QUAL;
        end
      end
      AB_QUAL: begin
        if (tick_i) begin
          if (!en_i || lvl_i) begin
            state_d = AB_IDLE;
          end else if (reached) begin
            state_d = AB_HOLD;
          end else begin
            cnt_d = cnt_inc[DBW-1:0];
          end
        end
      end
      AB_HOLD: begin
        if (lvl_i || (tick_i && !en_i)) begin
          state_d = AB_IDLE;
        end
      end
      default: state_d = AB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= AB_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign active_o = (state_q == AB_HOLD);

endmodule

// File: rtl/pab_key_mux.sv
module pab_key_mux #(
  parameter int NKEY = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active_i,
  input  logic [NKEY-1:0] sel_i,
  input  logic [NKEY-1:0] val_i,
  input  logic [NKEY-1:0] keys_i,
  output logic [NKEY-1:0] keys_o
);

  for (genvar g = 0; g < NKEY; g++) begin : g_key
    always_ff @(posedge clk) begin
      if (rst) begin
        keys_o[g] <= 1'b0;
      end else begin
        keys_o[g] <= (active_i && sel_i[g]) ? val_i[g] : keys_i[g];
      end
    end
  end

endmodule

// File: rtl/pwrkey_autoblock.sv
module pwrkey_autoblock #(
  parameter int NKEY = 3,
  parameter int DBW  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_i,
  input  logic            btn_i,
  input  logic [NKEY-1:0] keys_i,
  input  logic [DBW:0]    ab_ctrl_i,
  input  logic [NKEY-1:0] key_sel_i,
  input  logic [NKEY-1:0] key_val_i,
  output logic [NKEY-1:0] keys_o
);

  localparam int EN_BIT = DBW;

  logic fall;
  logic active;

  pab_edge_sampler u_edge (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .lvl_i  (btn_i),
    .fall_o (fall)
  );

  pab_press_fsm #(.DBW(DBW)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .en_i     (ab_ctrl_i[EN_BIT]),
    .lvl_i    (btn_i),
    .fall_i   (fall),
    .limit_i  (ab_ctrl_i[DBW-1:0]),
    .active_o (active)
  );

  pab_key_mux #(.NKEY(NKEY)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .active_i (active),
    .sel_i    (key_sel_i),
    .val_i    (key_val_i),
    .keys_i   (keys_i),
    .keys_o   (keys_o)
  );

endmodule

// File: rtl/pab_checker.sv
module pab_checker #(
  parameter int NKEY = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            tick_i,
  input logic            btn_i,
  input logic            en_i,
  input logic [NKEY-1:0] keys_i,
  input logic [NKEY-1:0] sel_i,
  input logic [NKEY-1:0] val_i,
  input logic            active_i,
  input logic [NKEY-1:0] keys_o
);

  p_arm_needed_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(active_i) |-> ($past(en_i) && $past(tick_i) && !$past(btn_i)));

  p_forced_level_r5: assert property (@(posedge clk) disable iff (rst)
    active_i |=> (((keys_o ^ $past(val_i)) & $past(sel_i)) == '0));

  p_pass_through_r6: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> (keys_o == $past(keys_i)));

  p_release_high_r7: assert property (@(posedge clk) disable iff (rst)
    (active_i && btn_i) |=> !active_i);

  p_disarm_release_r8: assert property (@(posedge clk) disable iff (rst)
    (active_i && tick_i && !en_i) |=> !active_i);

endmodule

bind pwrkey_autoblock pab_checker #(.NKEY(NKEY)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_i   (tick_i),
  .btn_i    (btn_i),
  .en_i     (ab_ctrl_i[DBW]),
  .keys_i   (keys_i),
  .sel_i    (key_sel_i),
  .val_i    (key_val_i),
  .active_i (active),
  .keys_o   (keys_o)
);

// File: tb/pwrkey_autoblock_bench.sv
module pwrkey_autoblock_bench;

  localparam int NKEY = 3;
  localparam int DBW  = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            tick = 1'b0;
  logic            btn = 1'b1;
  logic [NKEY-1:0] keys = '0;
  logic [DBW:0]    ctrl = '0;
  logic [NKEY-1:0] sel = '0;
  logic [NKEY-1:0] val = '0;
  logic [NKEY-1:0] keys_o;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  int    tick_div = 1;
  int    tick_cnt = 0;
  string cur_tag = "R9";

  // model state: 0 idle, 1 qualifying, 2 holding
  int              m_st = 0;
  int              m_cnt = 0;
  bit              m_prev = 0;
  logic [NKEY-1:0] m_out = '0;

  always #2 clk = ~clk;

  pwrkey_autoblock #(.NKEY(NKEY), .DBW(DBW)) u_pwrkey_autoblock (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .btn_i     (btn),
    .keys_i    (keys),
    .ab_ctrl_i (ctrl),
    .key_sel_i (sel),
    .key_val_i (val),
    .keys_o    (keys_o)
  );

  // strobe and key stimulus, changed away from the active edge
  always @(negedge clk) begin
    tick_cnt = tick_cnt + 1;
    tick = ((tick_cnt % tick_div) == 0);
    keys = NKEY'($urandom);
  end

  // behavioural reference
  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_prev = 0; m_out = '0;
    end else begin
      int  lim;
      int  nst;
      bit  en;
      en  = ctrl[DBW];
      lim = int'(ctrl[DBW-1:0]);
      for (int i = 0; i < NKEY; i++)
        m_out[i] = (m_st == 2 && sel[i]) ? val[i] : keys[i];
      nst = m_st;
      if (m_st == 0) begin
        if (tick && en && m_prev && !btn) begin
          m_cnt = 0;
          nst = (lim == 0) ? 2 : 1;
        end
      end else if (m_st == 1) begin
        if (tick) begin
          if (!en || btn) nst = 0;
          else begin
            m_cnt = m_cnt + 1;
            if (m_cnt >= lim) nst = 2;
          end
        end
      end else begin
        if (btn || (tick && !en)) nst = 0;
      end
      if (tick) m_prev = btn;
      m_st = nst;
    end
  end

  // compare every clock, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    cycles = cycles + 1;
    checks = checks + 1;
    if (keys_o !== m_out) begin
      errors = errors + 1;
      $display("FAIL %s cycle %0d keys_o actual %b expected %b", cur_tag, cycles, keys_o, m_out);
    end
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DBW:0] mk_ctrl(input bit en, input int lim);
    return {en, DBW'(lim)};
  endfunction

  initial begin
    // R9: reset state
    cyc(3);
    checks = checks + 1;
    if (keys_o !== '0) begin
      errors = errors + 1;
      $display("FAIL R9 reset keys_o actual %b expected 000", keys_o);
    end
    rst = 0;
    cur_tag = "R6";
    cyc(10);

    // R1: disarmed, press has no effect
    cur_tag = "R1";
    sel = 3'b111; val = 3'b111; ctrl = mk_ctrl(0, 2);
    btn = 0; cyc(12); btn = 1; cyc(5);

    // R5 / R3: armed with count 5, strobe every 2 clocks
    cur_tag = "R5";
    tick_div = 2; sel = 3'b101; val = 3'b001; ctrl = mk_ctrl(1, 5);
    btn = 0; cyc(30);
    // R7: release between strobes
    cur_tag = "R7";
    btn = 1; cyc(6);

    // R4: bounce during qualification
    cur_tag = "R4";
    btn = 0; cyc(4); btn = 1; cyc(2);
    btn = 0; cyc(8); btn = 1; cyc(4);
    btn = 0; cyc(20); btn = 1; cyc(4);

    // R3: zero count, strobe every 3 clocks
    cur_tag = "R3";
    tick_div = 3; sel = 3'b011; val = 3'b010; ctrl = mk_ctrl(1, 0);
    btn = 0; cyc(10); btn = 1; cyc(6);

    // R8: disarm while holding
    cur_tag = "R8";
    ctrl = mk_ctrl(1, 1);
    btn = 0; cyc(12); ctrl = mk_ctrl(0, 1); cyc(6); btn = 1; cyc(4);
    ctrl = mk_ctrl(1, 1);

    // R2: short lows between strobes
    cur_tag = "R2";
    tick_div = 5; ctrl = mk_ctrl(1, 0);
    for (int k = 0; k < 6; k++) begin
      btn = 0; cyc(2); btn = 1; cyc(3 + k);
    end

    // R10: largest count, then lowered mid-way
    cur_tag = "R10";
    tick_div = 1; sel = 3'b111; val = 3'b101; ctrl = mk_ctrl(1, 63);
    btn = 0; cyc(70); btn = 1; cyc(3);
    btn = 0; cyc(20); ctrl = mk_ctrl(1, 4); cyc(5); btn = 1; cyc(3);

    // R9: button held low through reset
    cur_tag = "R9";
    rst = 1; btn = 0; ctrl = mk_ctrl(1, 0); cyc(3);
    rst = 0; cyc(10);
    btn = 1; cyc(3); btn = 0; cyc(6); btn = 1; cyc(3);

    // mixed random stimulus
    cur_tag = "R6";
    for (int k = 0; k < 1500; k++) begin
      if (($urandom % 8) == 0) btn = ~btn;
      if (($urandom % 50) == 0) ctrl = mk_ctrl(($urandom % 4) != 0, int'($urandom % 6));
      if (($urandom % 40) == 0) begin sel = NKEY'($urandom); val = NKEY'($urandom); end
      if (($urandom % 100) == 0) tick_div = 1 + int'($urandom % 4);
      cyc(1);
    end

    cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule